// File: doc/BRIEF.md
# DMA Peripheral Handshake Acknowledge Unit

This unit sits on the controller side of a DMA engine and keeps track of request handshakes from up to 32 peripherals. Each peripheral has a 5-bit index. When a peripheral pulses its request line, the unit adds one to that peripheral's count of outstanding requests. The count holds at most four. A request that arrives while the count is full is reported on an overflow pulse and is not counted.

Completion notices and flush orders come in on a command port with its own valid/ready handshake. The unit sends each one to the addressed peripheral as a valid strobe with a 2-bit type code. The type stays frozen until that peripheral raises its ready line. When a single-done or burst-done acknowledge completes, the count drops by one. When a flush completes, the count is cleared.

A small set of thread slots lets channel threads wait on a peripheral. A thread is armed with a 5-bit index and stays busy until that peripheral has at least one outstanding request. It then gets a one-cycle wake pulse.

Top module: `pdh_ack_unit`

## Requirements
- R1: While reset is asserted and right after it is released, every outstanding count is zero: `periph_pending`, `periph_full` and `periph_ovf` are zero. `ack_valid` is zero, `ack_type` is 2'b00, `cmd_ready` is high, and no thread is busy or woken.
- R2: A one-cycle pulse on `periph_req[i]` raises the count of peripheral i by one. `periph_pending[i]` is high while the count is non-zero. `periph_full[i]` is high while the count equals four.
- R3: A request that arrives while the count is four, with no completing acknowledge to that peripheral in the same cycle, gives a one-cycle `periph_ovf[i]` pulse in the following cycle and leaves the count at four.
- R4: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. From the next cycle, `ack_valid[cmd_id]` is high and every other `ack_valid` bit is low. `ack_type` carries the command code: 2'b00 single done, 2'b01 burst done, 2'b10 flush.
- R5: While `ack_valid[i]` is high and `ack_ready[i]` is low, `ack_valid` and `ack_type` keep their values. The acknowledge completes on the edge where both are high, and `ack_valid` is low in the next cycle.
- R6: When a single-done or burst-done acknowledge completes, the addressed count drops by one. A completion at count zero leaves the count at zero.
- R7: When a flush acknowledge completes, the addressed count becomes zero. A request in that same cycle leaves the count at one.
- R8: `cmd_ready` is low while any acknowledge is waiting for ready, so at most one `ack_valid` bit is ever high.
- R9: A command with the reserved code 2'b11 is accepted and dropped. No `ack_valid` bit rises and no count changes.
- R10: A thread armed through `thr_start[t]` with index `thr_id[5t+4:5t]` shows `thr_busy[t]` from the next cycle. It stays busy until the bound peripheral has a non-zero count. Then, one cycle later, busy falls and `thr_wake[t]` pulses for one cycle. Requests to other peripherals do not wake it.
- R11: `thr_start[t]` while thread t is busy is ignored: the thread stays bound to its first index.
- R12: `ack_type` is 2'b00 whenever no `ack_valid` bit is high, and 2'b11 never appears on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| periph_req | input | 32 | One-cycle request pulse per peripheral |
| periph_pending | output | 32 | Count of the peripheral is non-zero |
| periph_full | output | 32 | Count of the peripheral equals four |
| periph_ovf | output | 32 | One-cycle pulse: request dropped at full count |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_id | input | 5 | Peripheral addressed by the command |
| cmd_kind | input | 2 | Command code (00 single, 01 burst, 10 flush, 11 dropped) |
| ack_valid | output | 32 | Acknowledge strobe, one bit per peripheral |
| ack_ready | input | 32 | Peripheral takes the acknowledge |
| ack_type | output | 2 | Type code of the acknowledge in flight |
| thr_start | input | 4 | Arm a waiting thread |
| thr_id | input | 20 | Packed 5-bit peripheral index per thread |
| thr_busy | output | 4 | Thread is waiting |
| thr_wake | output | 4 | One-cycle release pulse per thread |

## Verification
The hardest state to reach from the ports is a full count receiving one more request, followed by a drain that proves the extra request was never stored. The stimulus fills one peripheral with four pulses, sends a fifth and watches for the overflow pulse. It then completes exactly four single-done acknowledges and expects pending to clear on the last one. Stalling an acknowledge for several cycles while a second command is held on the port shows the frozen type and the back-pressure together. A second-arm attempt on a busy thread, followed by a request to the rejected index, shows that the first binding is kept.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

  typedef enum logic [1:0] {
    ACK_SINGLE = 2'b00,
    ACK_BURST  = 2'b01,
    ACK_FLUSH  = 2'b10,
    ACK_RSVD   = 2'b11
  } ack_kind_e;

  typedef enum logic {
    TH_IDLE = 1'b0,
    TH_WAIT = 1'b1
  } th_state_e;

endpackage

// File: rtl/pdh_cnt_bank.sv
module pdh_cnt_bank #(
  parameter int NUM_PERIPH      = 32,
  parameter int MAX_OUTSTANDING = 4,
  localparam int CNT_W          = $clog2(MAX_OUTSTANDING + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] req,
  input  logic [NUM_PERIPH-1:0] dec,
  input  logic [NUM_PERIPH-1:0] clr,
  output logic [NUM_PERIPH-1:0] pending,
  output logic [NUM_PERIPH-1:0] full,
  output logic [NUM_PERIPH-1:0] ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUTSTANDING);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q, ovf_d;
    logic             cnt_en;

    always_comb begin
      cnt_d = cnt_q;
      ovf_d = 1'b0;
      if (clr[i]) begin
        cnt_d = req[i] ? CNT_ONE : '0;
      end else if (req[i] && !dec[i]) begin
        if (cnt_q == CNT_MAX) ovf_d = 1'b1;
        else                  cnt_d = cnt_q + CNT_ONE;
      end else if (dec[i] && !req[i]) begin
        if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
      end else if (dec[i] && req[i] && cnt_q == '0) begin
        cnt_d = CNT_ONE;
      end
    end

    assign cnt_en = req[i] | dec[i] | clr[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        ovf_q <= ovf_d;
        if (cnt_en) cnt_q <= cnt_d;
      end
    end

    assign pending[i] = (cnt_q != '0);
    assign full[i]    = (cnt_q == CNT_MAX);
    assign ovf[i]     = ovf_q;
  end

endmodule

// File: rtl/pdh_ack_chan.sv
module pdh_ack_chan
  import pdh_pkg::*;
#(
  parameter int NUM_PERIPH = 32,
  localparam int ID_W      = $clog2(NUM_PERIPH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [ID_W-1:0]       cmd_id,
  input  logic [1:0]            cmd_kind,
  input  logic [NUM_PERIPH-1:0] ack_ready,
  output logic [NUM_PERIPH-1:0] ack_valid,
  output logic [1:0]            ack_type,
  output logic [NUM_PERIPH-1:0] dec,
  output logic [NUM_PERIPH-1:0] clr
);

  logic            act_valid_q, act_valid_d;
  logic [ID_W-1:0] act_id_q;
  ack_kind_e       act_kind_q;
  logic            accept, load, done;

  assign cmd_ready = !act_valid_q;
  assign accept    = cmd_valid && cmd_ready;
  assign load      = accept && (ack_kind_e'(cmd_kind) != ACK_RSVD);
  assign done      = act_valid_q && ack_ready[act_id_q];

  always_comb begin
    act_valid_d = act_valid_q;
    if (done) act_valid_d = 1'b0;
    if (load) act_valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid_q <= 1'b0;
      act_id_q    <= '0;
      act_kind_q  <= ACK_SINGLE;
    end else begin
      act_valid_q <= act_valid_d;
      if (load) begin
        act_id_q   <= cmd_id;
        act_kind_q <= ack_kind_e'(cmd_kind);
      end
    end
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_chan
    logic hit;
    assign hit          = act_valid_q && (act_id_q == ID_W'(i));
    assign ack_valid[i] = hit;
    assign dec[i]       = hit && ack_ready[i] && (act_kind_q != ACK_FLUSH);
    assign clr[i]       = hit && ack_ready[i] && (act_kind_q == ACK_FLUSH);
  end

  assign ack_type = act_valid_q ? act_kind_q : ACK_SINGLE;

endmodule

// File: rtl/pdh_wait_threads.sv
module pdh_wait_threads
  import pdh_pkg::*;
#(
  parameter int NUM_PERIPH  = 32,
  parameter int NUM_THREADS = 4,
  localparam int ID_W       = $clog2(NUM_PERIPH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_THREADS-1:0]      start,
  input  logic [NUM_THREADS*ID_W-1:0] bind_id,
  input  logic [NUM_PERIPH-1:0]       pending,
  output logic [NUM_THREADS-1:0]      busy,
  output logic [NUM_THREADS-1:0]      wake
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    th_state_e       st_q, st_d;
    logic [ID_W-1:0] id_q;
    logic            id_en;
    logic            wake_q, wake_d;

    always_comb begin
      st_d   = st_q;
      id_en  = 1'b0;
      wake_d = 1'b0;
      unique case (st_q)
        TH_IDLE: begin
          if (start[t]) begin
            st_d  = TH_WAIT;
            id_en = 1'b1;
          end
        end
        TH_WAIT: begin
          if (pending[id_q]) begin
            st_d   = TH_IDLE;
            wake_d = 1'b1;
          end
        end
        default: st_d = TH_IDLE;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= TH_IDLE;
        id_q   <= '0;
        wake_q <= 1'b0;
      end else begin
        st_q   <= st_d;
        wake_q <= wake_d;
        if (id_en) id_q <= bind_id[t*ID_W +: ID_W];
      end
    end

    assign busy[t] = (st_q == TH_WAIT);
    assign wake[t] = wake_q;
  end

endmodule

// File: rtl/pdh_ack_unit.sv
module pdh_ack_unit #(
  parameter int NUM_PERIPH      = 32,
  parameter int MAX_OUTSTANDING = 4,
  parameter int NUM_THREADS     = 4,
  localparam int ID_W           = $clog2(NUM_PERIPH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PERIPH-1:0]       periph_req,
  output logic [NUM_PERIPH-1:0]       periph_pending,
  output logic [NUM_PERIPH-1:0]       periph_full,
  output logic [NUM_PERIPH-1:0]       periph_ovf,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [ID_W-1:0]             cmd_id,
  input  logic [1:0]                  cmd_kind,
  output logic [NUM_PERIPH-1:0]       ack_valid,
  input  logic [NUM_PERIPH-1:0]       ack_ready,
  output logic [1:0]                  ack_type,
  input  logic [NUM_THREADS-1:0]      thr_start,
  input  logic [NUM_THREADS*ID_W-1:0] thr_id,
  output logic [NUM_THREADS-1:0]      thr_busy,
  output logic [NUM_THREADS-1:0]      thr_wake
);

  logic [NUM_PERIPH-1:0] dec_vec;
  logic [NUM_PERIPH-1:0] clr_vec;

  pdh_ack_chan #(
    .NUM_PERIPH(NUM_PERIPH)
  ) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_id   (cmd_id),
    .cmd_kind (cmd_kind),
    .ack_ready(ack_ready),
    .ack_valid(ack_valid),
    .ack_type (ack_type),
    .dec      (dec_vec),
    .clr      (clr_vec)
  );

  pdh_cnt_bank #(
    .NUM_PERIPH     (NUM_PERIPH),
    .MAX_OUTSTANDING(MAX_OUTSTANDING)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (periph_req),
    .dec    (dec_vec),
    .clr    (clr_vec),
    .pending(periph_pending),
    .full   (periph_full),
    .ovf    (periph_ovf)
  );

  pdh_wait_threads #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_THREADS(NUM_THREADS)
  ) u_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (thr_start),
    .bind_id(thr_id),
    .pending(periph_pending),
    .busy   (thr_busy),
    .wake   (thr_wake)
  );

endmodule

// File: rtl/pdh_ack_unit_chk.sv
module pdh_ack_unit_chk #(
  parameter int NUM_PERIPH  = 32,
  parameter int NUM_THREADS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_PERIPH-1:0]  periph_pending,
  input logic [NUM_PERIPH-1:0]  periph_full,
  input logic [NUM_PERIPH-1:0]  periph_ovf,
  input logic                   cmd_ready,
  input logic [NUM_PERIPH-1:0]  ack_valid,
  input logic [NUM_PERIPH-1:0]  ack_ready,
  input logic [1:0]             ack_type,
  input logic [NUM_THREADS-1:0] thr_busy,
  input logic [NUM_THREADS-1:0] thr_wake
);

  // R5: a stalled acknowledge keeps its target and type
  p_type_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_valid & ~ack_ready)) |=> (ack_valid == $past(ack_valid)) && $stable(ack_type));

  // R12: the reserved code never leaves the block
  p_no_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_type != 2'b11);

  // R12: the type bus is zero with no strobe
  p_idle_type_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ack_valid) |-> ack_type == 2'b00);

  // R8: one acknowledge at a time
  p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_valid));

  // R8: commands held off while an acknowledge is waiting
  p_cmd_bp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_valid) |-> !cmd_ready);

  // R2: full implies pending
  p_full_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_full & ~periph_pending) == '0);

  // R3: an overflow pulse only follows a full count
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ovf & ~$past(periph_full)) == '0);

  // R10: a wake pulse only follows a busy thread
  p_wake_after_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wake & ~$past(thr_busy)) == '0);

  // R10: a woken thread is no longer busy
  p_wake_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wake & thr_busy) == '0);

endmodule

bind pdh_ack_unit pdh_ack_unit_chk #(
  .NUM_PERIPH (NUM_PERIPH),
  .NUM_THREADS(NUM_THREADS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .periph_pending(periph_pending),
  .periph_full   (periph_full),
  .periph_ovf    (periph_ovf),
  .cmd_ready     (cmd_ready),
  .ack_valid     (ack_valid),
  .ack_ready     (ack_ready),
  .ack_type      (ack_type),
  .thr_busy      (thr_busy),
  .thr_wake      (thr_wake)
);

// File: tb/tb_pdh_ack_unit.sv
`timescale 1ns/1ps
module tb_pdh_ack_unit;

  localparam int NP = 32;
  localparam int NT = 4;
  localparam int IW = 5;

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   periph_req;
  logic [NP-1:0]   periph_pending, periph_full, periph_ovf;
  logic            cmd_valid, cmd_ready;
  logic [IW-1:0]   cmd_id;
  logic [1:0]      cmd_kind;
  logic [NP-1:0]   ack_valid, ack_ready;
  logic [1:0]      ack_type;
  logic [NT-1:0]   thr_start, thr_busy, thr_wake;
  logic [NT*IW-1:0] thr_id;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  pdh_ack_unit dut (
    .clk(clk), .rst_n(rst_n),
    .periph_req(periph_req), .periph_pending(periph_pending),
    .periph_full(periph_full), .periph_ovf(periph_ovf),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id), .cmd_kind(cmd_kind),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_type(ack_type),
    .thr_start(thr_start), .thr_id(thr_id), .thr_busy(thr_busy), .thr_wake(thr_wake)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_req(int id);
    periph_req[id] = 1'b1;
    step();
    periph_req = '0;
  endtask

  task automatic send_cmd(int id, logic [1:0] kind);
    cmd_valid = 1'b1;
    cmd_id    = IW'(id);
    cmd_kind  = kind;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic complete(int id);
    ack_ready[id] = 1'b1;
    step();
    ack_ready = '0;
  endtask

  task automatic flush_clean(int id);
    send_cmd(id, 2'b10);
    complete(id);
  endtask

  task automatic t_reset();
    check("R1 pending", 64'(periph_pending), 0);
    check("R1 full", 64'(periph_full), 0);
    check("R1 ack_valid", 64'(ack_valid), 0);
    check("R1 ack_type", 64'(ack_type), 0);
    check("R1 cmd_ready", 64'(cmd_ready), 1);
    check("R1 busy", 64'(thr_busy), 0);
  endtask

  task automatic t_fill_overflow();
    for (int k = 0; k < 4; k++) pulse_req(5);
    check("R2 pending after 4", 64'(periph_pending[5]), 1);
    check("R2 full after 4", 64'(periph_full[5]), 1);
    check("R3 no ovf before", 64'(periph_ovf), 0);
    pulse_req(5);
    check("R3 ovf pulse", 64'(periph_ovf), 64'(NP'(1) << 5));
    step();
    check("R3 ovf one cycle", 64'(periph_ovf), 0);
    for (int k = 0; k < 4; k++) begin
      send_cmd(5, 2'b00);
      check("R4 single target", 64'(ack_valid), 64'(NP'(1) << 5));
      check("R4 single code", 64'(ack_type), 0);
      complete(5);
      check("R5 valid drops", 64'(ack_valid), 0);
      check("R3 drain pending", 64'(periph_pending[5]), (k < 3) ? 1 : 0);
    end
    check("R12 idle type", 64'(ack_type), 0);
  endtask

  task automatic t_stall_backpressure();
    pulse_req(9);
    send_cmd(9, 2'b01);
    cmd_valid = 1'b1; cmd_id = IW'(10); cmd_kind = 2'b10;
    for (int k = 0; k < 3; k++) begin
      check("R5 held valid", 64'(ack_valid), 64'(NP'(1) << 9));
      check("R4 burst code", 64'(ack_type), 1);
      check("R8 cmd_ready low", 64'(cmd_ready), 0);
      step();
    end
    complete(9);
    check("R6 burst dec", 64'(periph_pending[9]), 0);
    check("R8 ready after done", 64'(cmd_ready), 1);
    step();
    cmd_valid = 1'b0;
    check("R4 queued flush target", 64'(ack_valid), 64'(NP'(1) << 10));
    check("R4 flush code", 64'(ack_type), 2);
    complete(10);
    check("R8 channel idle", 64'(ack_valid), 0);
  endtask

  task automatic t_flush();
    for (int k = 0; k < 3; k++) pulse_req(20);
    send_cmd(20, 2'b10);
    complete(20);
    check("R7 flush clears", 64'(periph_pending[20]), 0);
    pulse_req(20);
    pulse_req(20);
    send_cmd(20, 2'b10);
    ack_ready[20] = 1'b1;
    periph_req[20] = 1'b1;
    step();
    ack_ready = '0; periph_req = '0;
    check("R7 flush with req", 64'(periph_pending[20]), 1);
    send_cmd(20, 2'b00);
    complete(20);
    check("R7 count was one", 64'(periph_pending[20]), 0);
  endtask

  task automatic t_zero_dec();
    send_cmd(3, 2'b00);
    complete(3);
    check("R6 zero stays", 64'(periph_pending[3]), 0);
    pulse_req(3);
    check("R6 one after req", 64'(periph_pending[3]), 1);
    send_cmd(3, 2'b01);
    complete(3);
    check("R6 back to zero", 64'(periph_pending[3]), 0);
  endtask

  task automatic t_reserved();
    pulse_req(7);
    send_cmd(7, 2'b11);
    check("R9 no strobe", 64'(ack_valid), 0);
    check("R9 ready kept", 64'(cmd_ready), 1);
    check("R9 count kept", 64'(periph_pending[7]), 1);
    check("R12 type zero", 64'(ack_type), 0);
    flush_clean(7);
  endtask

  task automatic t_wait();
    thr_id[1*IW +: IW] = IW'(12);
    thr_start[1] = 1'b1;
    step();
    thr_start = '0;
    check("R10 busy", 64'(thr_busy[1]), 1);
    step(); step();
    check("R10 still waiting", 64'(thr_wake[1]), 0);
    pulse_req(13);
    step();
    check("R10 other id no wake", 64'(thr_wake), 0);
    check("R10 busy kept", 64'(thr_busy[1]), 1);
    pulse_req(12);
    check("R10 not yet", 64'(thr_wake[1]), 0);
    step();
    check("R10 wake", 64'(thr_wake), 64'(4'b0010));
    check("R10 busy falls", 64'(thr_busy[1]), 0);
    step();
    check("R10 wake one cycle", 64'(thr_wake), 0);
    thr_id[2*IW +: IW] = IW'(13);
    thr_start[2] = 1'b1;
    step();
    thr_start = '0;
    check("R10 armed on pending", 64'(thr_busy[2]), 1);
    step();
    check("R10 immediate wake", 64'(thr_wake), 64'(4'b0100));
    flush_clean(12);
    flush_clean(13);
  endtask

  task automatic t_rearm();
    thr_id[0 +: IW] = IW'(30);
    thr_start[0] = 1'b1;
    step();
    thr_id[0 +: IW] = IW'(31);
    step();
    thr_start = '0;
    check("R11 busy", 64'(thr_busy[0]), 1);
    pulse_req(31);
    step(); step();
    check("R11 second id ignored", 64'(thr_wake[0]), 0);
    check("R11 still busy", 64'(thr_busy[0]), 1);
    pulse_req(30);
    step();
    check("R11 first id wakes", 64'(thr_wake[0]), 1);
    flush_clean(30);
    flush_clean(31);
  endtask

  initial begin
    rst_n = 1'b0;
    periph_req = '0; cmd_valid = 1'b0; cmd_id = '0; cmd_kind = '0;
    ack_ready = '0; thr_start = '0; thr_id = '0;
    repeat (4) step();
    check("R1 in reset", 64'(periph_pending | ack_valid), 0);
    rst_n = 1'b1;
    step();
    t_reset();
    t_fill_overflow();
    t_stall_backpressure();
    t_flush();
    t_zero_dec();
    t_reserved();
    t_wait();
    t_rearm();
    step();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule